// File: doc/BRIEF.md
# Four-Pixel Region Hit Buffer with Trigger-Matched Readout

This block is the digital logic shared by four neighbouring pixels of a hybrid pixel readout chip. Each pixel delivers a discriminator level. The block measures how long each pixel stays over threshold and groups hits that begin close together into one event. It files each event into one of a small pool of buffer slots. Each slot carries its own latency countdown and one ToT nibble per pixel.

When a slot's countdown expires, the block samples the level-1 trigger input in that cycle. With the trigger present, the slot is queued for readout. Without it, the slot is quietly released, so unmatched hits never reach the column bus. Queued events leave one word per clock while the read token is held. With nothing queued, the token is handed straight on.

A pixel that crosses threshold late, while a neighbour's event is still open, is filed in that event's slot. The late pixel is placed in time by its position, not by its own leading edge. The `region_busy` output tells the clock-gating logic whether any slot is occupied. The programmed latency must be held steady while `region_busy` is high, and it must exceed the longest event duration.

Top module: `pixreg_hitbuf`

## Requirements
- R1: Out of reset `rd_valid` is 0, `overflow` is 0, `region_busy` is 0, and `tok_out` follows `tok_in`.
- R2: A rising pixel input sampled while no event is open opens a new event. The event takes the lowest-numbered free slot, and that number appears as the 3-bit tag in bits [2:0] of its readout word.
- R3: A pixel that rises while an event is open joins that event. It joins only once per event. The event closes in the first cycle in which none of its joined pixels is still high.
- R4: A pixel's ToT is the number of consecutive clock samples at which its input was high, starting at its rising sample. The value saturates at 14 (0xE). Code 0xF marks a pixel that did not take part in the event.
- R5: An event whose first sample is at clock edge k is read out only if `trig` is high at edge k+latency+1. Otherwise its slot is freed at that edge and no word is produced.
- R6: Queued events leave in the order their triggers matched, one per clock while `tok_in` is high, with `rd_valid` high in the cycle after the edge that accepted the token. The word layout is: bits [24:19] `region_addr`, then the ToT of pixel 3, 2, 1 and 0 in bits [18:15], [14:11], [10:7] and [6:3], then the slot tag in bits [2:0].
- R7: `tok_out` equals `tok_in` while no event is queued for readout, and is 0 while at least one is queued.
- R8: A rising edge that would open an event while all five slots are occupied is dropped. It also sets `overflow`, which stays set until reset.
- R9: `region_busy` is high exactly while at least one slot is occupied, whether pending or queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc | input | 4 | Discriminator level of each pixel |
| trig | input | 1 | Level-1 trigger decision |
| latency | input | 8 | Trigger latency in clock cycles |
| region_addr | input | 6 | Address of this region on the column |
| tok_in | input | 1 | Read token from the previous region |
| tok_out | output | 1 | Read token passed to the next region |
| rd_valid | output | 1 | Readout word valid |
| rd_word | output | 25 | Region address, four ToT codes, slot tag |
| overflow | output | 1 | Sticky lost-hit flag |
| region_busy | output | 1 | Any slot occupied (clock-gate request) |

## Verification
Several properties are asserted on every cycle. Allocation always targets a free slot. An occupied slot never holds a zero ToT. A slot turns ready only in a cycle where the trigger was sampled high. The ready queue never overfills. A word appears only after a held token. The overflow flag never clears.

Other behaviour can only be shown by the bench scenarios, compared against a cycle-by-cycle reference model. These are: exact trigger alignment one cycle either side of expiry, late pixels joining an open event, ToT saturation, oldest-first order under a withheld token, and loss of a sixth concurrent event.

// File: rtl/pixreg_pkg.sv
package pixreg_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_PEND  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;
endpackage

// File: rtl/pixreg_evt_ctl.sv
module pixreg_evt_ctl #(
    parameter int NPIX  = 4,
    parameter int NSLOT = 5,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIX-1:0]  disc,
    input  logic [NSLOT-1:0] free_vec,
    output logic             alloc,
    output logic [SW-1:0]    alloc_idx,
    output logic [SW-1:0]    wr_slot,
    output logic [NPIX-1:0]  pix_init,
    output logic [NPIX-1:0]  pix_inc,
    output logic             overflow
);
    typedef struct packed {
        logic [NPIX-1:0] prev;
        logic [NPIX-1:0] active;
        logic [NPIX-1:0] joined;
        logic            open;
        logic [SW-1:0]   oslot;
        logic            ovf;
    } evt_t;

    evt_t q, d;
    logic [NPIX-1:0] rise;
    logic            cur_open;

    always_comb begin
        d         = q;
        rise      = disc & ~q.prev;
        alloc_idx = '0;
        for (int s = NSLOT-1; s >= 0; s--) begin
            if (free_vec[s]) alloc_idx = SW'(s);
        end
        alloc    = !q.open && (|rise) && (|free_vec);
        cur_open = q.open || alloc;
        wr_slot  = alloc ? alloc_idx : q.oslot;
        pix_init = cur_open ? (rise & ~q.joined) : '0;
        pix_inc  = q.active & disc;
        d.prev   = disc;
        d.active = pix_inc | pix_init;
        d.joined = q.joined | pix_init;
        d.open   = cur_open && (|d.active);
        d.oslot  = wr_slot;
        if (!d.open) d.joined = '0;
        if (!q.open && (|rise) && !(|free_vec)) d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign overflow = q.ovf;

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovf |=> q.ovf);

    // R2
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> free_vec[alloc_idx]);

    // R4
    inc_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pix_inc) |-> !free_vec[wr_slot]);
endmodule

// File: rtl/pixreg_slot_pool.sv
module pixreg_slot_pool
    import pixreg_pkg::*;
#(
    parameter int NPIX  = 4,
    parameter int NSLOT = 5,
    parameter int TOTW  = 4,
    parameter int LATW  = 8,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc,
    input  logic [SW-1:0]        alloc_idx,
    input  logic [LATW-1:0]      latency,
    input  logic [SW-1:0]        wr_slot,
    input  logic [NPIX-1:0]      pix_init,
    input  logic [NPIX-1:0]      pix_inc,
    input  logic                 trig,
    input  logic                 pop,
    input  logic [SW-1:0]        pop_idx,
    output logic [NSLOT-1:0]     free_vec,
    output logic [NSLOT-1:0]     match,
    output logic [NPIX*TOTW-1:0] pop_tot
);
    localparam logic [TOTW-1:0] TOT_NONE = '1;
    localparam logic [TOTW-1:0] TOT_MAX  = TOT_NONE - TOTW'(1);
    localparam logic [TOTW-1:0] TOT_ONE  = TOTW'(1);

    typedef struct packed {
        slot_state_e                st;
        logic [LATW-1:0]            cnt;
        logic [NPIX-1:0][TOTW-1:0]  tot;
    } slot_t;

    slot_t [NSLOT-1:0] q, d;

    always_comb begin
        d     = q;
        match = '0;
        for (int s = 0; s < NSLOT; s++) begin
            case (q[s].st)
                SLOT_FREE: begin
                    if (alloc && alloc_idx == SW'(s)) begin
                        d[s].st  = SLOT_PEND;
                        d[s].cnt = latency;
                        for (int p = 0; p < NPIX; p++)
                            d[s].tot[p] = pix_init[p] ? TOT_ONE : TOT_NONE;
                    end
                end
                SLOT_PEND: begin
                    if (q[s].cnt == '0) begin
                        if (trig) begin
                            d[s].st  = SLOT_READY;
                            match[s] = 1'b1;
                        end else begin
                            d[s].st = SLOT_FREE;
                        end
                    end else begin
                        d[s].cnt = q[s].cnt - LATW'(1);
                    end
                    if (wr_slot == SW'(s)) begin
                        for (int p = 0; p < NPIX; p++) begin
                            if (pix_init[p])
                                d[s].tot[p] = TOT_ONE;
                            else if (pix_inc[p] && q[s].tot[p] != TOT_MAX)
                                d[s].tot[p] = q[s].tot[p] + TOTW'(1);
                        end
                    end
                end
                SLOT_READY: begin
                    if (pop && pop_idx == SW'(s)) d[s].st = SLOT_FREE;
                end
                default: d[s].st = SLOT_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSLOT; s++) begin
                q[s].st  <= SLOT_FREE;
                q[s].cnt <= '0;
                q[s].tot <= '1;
            end
        end else begin
            q <= d;
        end
    end

    always_comb begin
        pop_tot = '0;
        if (int'(pop_idx) < NSLOT) pop_tot = q[pop_idx].tot;
    end

    generate
        for (genvar gs = 0; gs < NSLOT; gs++) begin : g_slot
            assign free_vec[gs] = (q[gs].st == SLOT_FREE);

            // R5
            ready_on_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(q[gs].st == SLOT_READY) |-> $past(trig));

            // R6
            pop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pop && pop_idx == SW'(gs)) |-> (q[gs].st == SLOT_READY));

            for (genvar gp = 0; gp < NPIX; gp++) begin : g_pix
                // R4
                tot_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (q[gs].st != SLOT_FREE) |-> (q[gs].tot[gp] != '0));
            end
        end
    endgenerate
endmodule

// File: rtl/pixreg_read_q.sv
module pixreg_read_q #(
    parameter int NPIX  = 4,
    parameter int NSLOT = 5,
    parameter int TOTW  = 4,
    parameter int ADDRW = 6,
    parameter int SW    = $clog2(NSLOT),
    parameter int WW    = ADDRW + NPIX*TOTW + SW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSLOT-1:0]     match,
    input  logic                 tok_in,
    input  logic [ADDRW-1:0]     region_addr,
    input  logic [NPIX*TOTW-1:0] head_tot,
    output logic [SW-1:0]        head_idx,
    output logic                 pop,
    output logic                 tok_out,
    output logic                 rd_valid,
    output logic [WW-1:0]        rd_word
);
    localparam logic [SW:0] DEPTH = (SW+1)'(NSLOT);

    typedef struct packed {
        logic [NSLOT-1:0][SW-1:0] mem;
        logic [SW-1:0]            wp;
        logic [SW-1:0]            rp;
        logic [SW:0]              cnt;
        logic                     vld;
        logic [WW-1:0]            word;
    } rq_t;

    rq_t q, d;
    logic          push;
    logic [SW-1:0] push_idx;

    always_comb begin
        d        = q;
        push     = |match;
        push_idx = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (match[s]) push_idx = SW'(s);
        end
        head_idx = q.mem[q.rp];
        pop      = tok_in && (q.cnt != '0);
        if (push) begin
            d.mem[q.wp] = push_idx;
            d.wp = (q.wp == SW'(NSLOT-1)) ? '0 : q.wp + SW'(1);
        end
        if (pop) d.rp = (q.rp == SW'(NSLOT-1)) ? '0 : q.rp + SW'(1);
        d.cnt  = q.cnt + (push ? (SW+1)'(1) : '0) - (pop ? (SW+1)'(1) : '0);
        d.vld  = pop;
        d.word = pop ? {region_addr, head_tot, head_idx} : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tok_out  = tok_in && (q.cnt == '0);
    assign rd_valid = q.vld;
    assign rd_word  = q.word;

    // R6
    fifo_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (q.cnt < DEPTH));

    // R6
    one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);
endmodule

// File: rtl/pixreg_hitbuf.sv
module pixreg_hitbuf #(
    parameter int NPIX  = 4,
    parameter int NSLOT = 5,
    parameter int TOTW  = 4,
    parameter int LATW  = 8,
    parameter int ADDRW = 6
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [NPIX-1:0]                            disc,
    input  logic                                       trig,
    input  logic [LATW-1:0]                            latency,
    input  logic [ADDRW-1:0]                           region_addr,
    input  logic                                       tok_in,
    output logic                                       tok_out,
    output logic                                       rd_valid,
    output logic [ADDRW+NPIX*TOTW+$clog2(NSLOT)-1:0]   rd_word,
    output logic                                       overflow,
    output logic                                       region_busy
);
    localparam int SW = $clog2(NSLOT);

    logic                 alloc;
    logic [SW-1:0]        alloc_idx;
    logic [SW-1:0]        wr_slot;
    logic [NPIX-1:0]      pix_init;
    logic [NPIX-1:0]      pix_inc;
    logic [NSLOT-1:0]     free_vec;
    logic [NSLOT-1:0]     match;
    logic [NPIX*TOTW-1:0] head_tot;
    logic [SW-1:0]        head_idx;
    logic                 pop;

    pixreg_evt_ctl #(.NPIX(NPIX), .NSLOT(NSLOT), .SW(SW)) u_evt (
        .clk(clk), .rst_n(rst_n), .disc(disc), .free_vec(free_vec),
        .alloc(alloc), .alloc_idx(alloc_idx), .wr_slot(wr_slot),
        .pix_init(pix_init), .pix_inc(pix_inc), .overflow(overflow)
    );

    pixreg_slot_pool #(.NPIX(NPIX), .NSLOT(NSLOT), .TOTW(TOTW), .LATW(LATW), .SW(SW)) u_pool (
        .clk(clk), .rst_n(rst_n), .alloc(alloc), .alloc_idx(alloc_idx),
        .latency(latency), .wr_slot(wr_slot), .pix_init(pix_init),
        .pix_inc(pix_inc), .trig(trig), .pop(pop), .pop_idx(head_idx),
        .free_vec(free_vec), .match(match), .pop_tot(head_tot)
    );

    pixreg_read_q #(.NPIX(NPIX), .NSLOT(NSLOT), .TOTW(TOTW), .ADDRW(ADDRW), .SW(SW)) u_rdq (
        .clk(clk), .rst_n(rst_n), .match(match), .tok_in(tok_in),
        .region_addr(region_addr), .head_tot(head_tot), .head_idx(head_idx),
        .pop(pop), .tok_out(tok_out), .rd_valid(rd_valid), .rd_word(rd_word)
    );

    assign region_busy = ~(&free_vec);

    // R6
    rd_after_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(tok_in));

    // R9
    busy_after_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> region_busy);

    // R7
    tok_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !tok_out);
endmodule

// File: tb/pixreg_hitbuf_bench.sv
`timescale 1ns/1ps
module pixreg_hitbuf_bench;
    localparam logic [5:0] ADDR = 6'h2D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  disc = '0;
    logic        trig = 1'b0;
    logic [7:0]  latency = 8'd20;
    logic        tok_in = 1'b1;
    logic        tok_out, rd_valid, overflow, region_busy;
    logic [24:0] rd_word;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 0;
    logic [24:0] got[$];

    // behavioural reference state
    int  cyc;
    int  st[5];          // 0 free, 1 pending, 2 queued
    int  t0[5];
    int  lat_at[5];
    int  mtot[5][4];
    bit  m_prev[4], m_act[4], m_join[4];
    bit  m_open;
    int  m_oslot;
    bit  m_ovf;
    int  rq[$];
    bit  e_valid;
    logic [24:0] e_word;

    always #2 clk = ~clk;

    pixreg_hitbuf u_pixreg_hitbuf (
        .clk(clk), .rst_n(rst_n), .disc(disc), .trig(trig), .latency(latency),
        .region_addr(ADDR), .tok_in(tok_in), .tok_out(tok_out),
        .rd_valid(rd_valid), .rd_word(rd_word), .overflow(overflow),
        .region_busy(region_busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [24:0] mk(input int s);
        return {ADDR, 4'(mtot[s][3]), 4'(mtot[s][2]), 4'(mtot[s][1]), 4'(mtot[s][0]), 3'(s)};
    endfunction

    function automatic bit m_busy();
        for (int s = 0; s < 5; s++) if (st[s] != 0) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; m_open = 0; m_oslot = 0; m_ovf = 0; e_valid = 0; e_word = '0;
            rq.delete();
            for (int s = 0; s < 5; s++) st[s] = 0;
            for (int p = 0; p < 4; p++) begin m_prev[p] = 0; m_act[p] = 0; m_join[p] = 0; end
        end else begin
            int  ost[5];
            bit  rise[4];
            bit  any_rise;
            bit  was_open;
            bit  na[4];
            bit  any_act;
            int  fs;
            for (int s = 0; s < 5; s++) ost[s] = st[s];
            was_open = m_open;
            e_valid = 0; e_word = '0;
            if (tok_in && rq.size() > 0) begin
                fs = rq.pop_front();
                e_valid = 1; e_word = mk(fs); st[fs] = 0;
            end
            for (int s = 0; s < 5; s++) begin
                if (ost[s] == 1 && cyc == t0[s] + lat_at[s] + 1) begin
                    if (trig) begin st[s] = 2; rq.push_back(s); end
                    else st[s] = 0;
                end
            end
            any_rise = 0;
            for (int p = 0; p < 4; p++) begin
                rise[p] = disc[p] && !m_prev[p];
                any_rise |= rise[p];
            end
            if (!was_open && any_rise) begin
                fs = -1;
                for (int s = 4; s >= 0; s--) if (ost[s] == 0) fs = s;
                if (fs >= 0) begin
                    st[fs] = 1; t0[fs] = cyc; lat_at[fs] = latency;
                    for (int p = 0; p < 4; p++) mtot[fs][p] = 15;
                    m_open = 1; m_oslot = fs;
                end else m_ovf = 1;
            end
            any_act = 0;
            for (int p = 0; p < 4; p++) begin
                na[p] = 0;
                if (m_act[p] && disc[p]) begin
                    na[p] = 1;
                    if (mtot[m_oslot][p] < 14) mtot[m_oslot][p]++;
                end
                if (m_open && rise[p] && !m_join[p]) begin
                    na[p] = 1; m_join[p] = 1; mtot[m_oslot][p] = 1;
                end
                m_act[p] = na[p];
                any_act |= na[p];
                m_prev[p] = disc[p];
            end
            if (m_open && !any_act) begin
                m_open = 0;
                for (int p = 0; p < 4; p++) m_join[p] = 0;
            end
            cyc++;
        end
    end

    always @(posedge clk) begin
        #1;
        if (rd_valid) got.push_back(rd_word);
        if (cmp_en) begin
            chk(rd_valid === e_valid, "R5 R6 rd_valid", 32'(rd_valid), 32'(e_valid));
            if (e_valid) chk(rd_word === e_word, "R4 R6 rd_word", 32'(rd_word), 32'(e_word));
            chk(tok_out === (tok_in && rq.size() == 0), "R7 tok_out", 32'(tok_out), 32'(tok_in && rq.size() == 0));
            chk(overflow === m_ovf, "R8 overflow", 32'(overflow), 32'(m_ovf));
            chk(region_busy === m_busy(), "R9 region_busy", 32'(region_busy), 32'(m_busy()));
        end
    end

    task automatic wait_idle();
        disc = '0; trig = 0;
        while (region_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        #800000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int n0;
        repeat (4) @(negedge clk);
        // R1 during and after reset
        chk(rd_valid === 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
        chk(overflow === 1'b0, "R1 overflow", 32'(overflow), 0);
        chk(region_busy === 1'b0, "R1 region_busy", 32'(region_busy), 0);
        chk(tok_out === 1'b1, "R1 tok_out", 32'(tok_out), 1);
        rst_n = 1; cmp_en = 1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R5: join and saturation, trigger on the expiry sample
        n0 = got.size(); latency = 20; tok_in = 1;
        for (int t = 0; t < 60; t++) begin
            disc[0] = (t < 3);
            disc[2] = (t >= 1 && t < 17);
            trig = (t == 21);
            @(negedge clk);
        end
        chk(got.size() == n0 + 1, "R5 matched count", 32'(got.size() - n0), 1);
        if (got.size() == n0 + 1)
            chk(got[n0] === {ADDR, 4'hF, 4'hE, 4'hF, 4'h3, 3'd0}, "R2 R3 R4 word",
                32'(got[n0]), 32'({ADDR, 4'hF, 4'hE, 4'hF, 4'h3, 3'd0}));

        // R5: trigger one cycle early and one late
        wait_idle(); n0 = got.size();
        for (int t = 0; t < 40; t++) begin
            disc[1] = (t < 2);
            trig = (t == 20 || t == 22);
            @(negedge clk);
        end
        chk(got.size() == n0, "R5 unmatched dropped", 32'(got.size() - n0), 0);
        chk(region_busy === 1'b0, "R9 idle after expiry", 32'(region_busy), 0);

        // R6 R7: two queued events, token withheld then granted
        wait_idle(); n0 = got.size(); tok_in = 0;
        for (int t = 0; t < 40; t++) begin
            disc[3] = (t < 2);
            disc[0] = (t >= 6 && t < 8);
            trig = (t == 21 || t == 27);
            @(negedge clk);
        end
        tok_in = 1; #1;
        chk(tok_out === 1'b0, "R7 token held", 32'(tok_out), 0);
        repeat (5) @(negedge clk);
        chk(got.size() == n0 + 2, "R6 queued count", 32'(got.size() - n0), 2);
        if (got.size() == n0 + 2) begin
            chk(got[n0][2:0] == 3'd0, "R6 first tag", 32'(got[n0][2:0]), 0);
            chk(got[n0+1][2:0] == 3'd1, "R6 second tag", 32'(got[n0+1][2:0]), 1);
        end
        #1 chk(tok_out === 1'b1, "R7 token passed", 32'(tok_out), 1);

        // random frames against the reference model
        wait_idle(); latency = 30;
        for (int f = 0; f < 250; f++) begin
            int st_p[4];
            int ln_p[4];
            for (int p = 0; p < 4; p++) begin
                st_p[p] = ($urandom_range(1) == 1) ? int'($urandom_range(5)) : 99;
                ln_p[p] = int'($urandom_range(8, 1));
            end
            for (int t = 0; t < 16; t++) begin
                for (int p = 0; p < 4; p++) disc[p] = (t >= st_p[p] && t < st_p[p] + ln_p[p]);
                trig = ($urandom_range(9) < 3);
                tok_in = ($urandom_range(9) < 6);
                @(negedge clk);
            end
        end
        tok_in = 1;

        // R8: six events while five slots are held
        wait_idle(); latency = 200; n0 = got.size();
        for (int t = 0; t < 48; t++) begin
            disc[0] = ((t % 8) < 2);
            @(negedge clk);
        end
        disc = '0;
        chk(overflow === 1'b1, "R8 overflow set", 32'(overflow), 1);
        repeat (230) @(negedge clk);
        chk(region_busy === 1'b0, "R9 all expired", 32'(region_busy), 0);
        chk(overflow === 1'b1, "R8 overflow sticky", 32'(overflow), 1);
        chk(got.size() == n0, "R5 no words without trigger", 32'(got.size() - n0), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule